// File: doc/BRIEF.md
# Slot-Paced Full-Duplex Serial Link Master

This block drives one side of a point-to-point, clock-synchronous serial link between two controllers, and it is the only side that makes the clock. An internal frame timer gives a tick on a period chosen from two values. On each tick the block raises its chip-select and moves a packet of 25 bytes. Each byte goes out most significant bit first on `mosi` while the peer's byte comes in on `miso` on the same clocks. Outgoing bytes are read from a transmit register file that the host loads through a write port. Incoming bytes go into a receive register file that the host reads through an address/data pair.

Byte transfers start only on slot boundaries, which are a fixed number of system cycles apart and counted from the rise of chip-select. At each boundary the block looks at the peer's `busy` line. If it is high, that slot passes with no clocks and the same byte is offered again at the next boundary. The packet therefore always carries every byte in index order, even when it runs longer. A one-cycle `done` pulse marks the cycle in which chip-select drops. A frame tick that lands while a packet is still open is dropped, and a sticky `overrun` flag records it.

Top module: `busy_serial_master`

## Requirements
- R1: Out of reset `cs`, `sclk`, `mosi`, `done` and `overrun` are all low, and they stay that way until the first frame tick.
- R2: Chip-select rises once per frame. Frames are `FRAME_A_CYC` system cycles long while `frame_sel`=0 and `FRAME_B_CYC` cycles while `frame_sel`=1. `frame_sel` is sampled at each frame boundary and sets the length of the frame that boundary opens.
- R3: Each chip-select window carries exactly `NBYTES` (25) bytes of `DW` (8) bits, which is 200 rising `sclk` edges.
- R4: `sclk` has a period of 2·`HALF_CYC` system cycles and is low whenever `cs` is low. When `busy` is low, the first rising edge comes `HALF_CYC`+1 cycles after `cs` rises.
- R5: Transmit entry k is sent as byte k, most significant bit first. `mosi` changes only while `sclk` is low, so it is stable at every rising edge, and it is low when no byte is in flight.
- R6: `miso` is sampled on rising `sclk` edges, first bit as the MSB. Byte k of a packet is written to receive entry k and can be read through `rx_addr`/`rx_rdata` (combinational read).
- R7: With `busy` low, consecutive bytes start exactly `SLOT_CYC` system cycles apart.
- R8: If `busy` is high at a slot boundary, no clocks are made in that slot and the byte index does not advance. Each skipped slot delays the remaining bytes by exactly `SLOT_CYC` cycles.
- R9: `done` is high for exactly one cycle: the first cycle in which `cs` is low after a packet. It is never high at any other time.
- R10: A frame tick that arrives while `cs` is high does not restart or cut short the packet. It sets `overrun`, which then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_sel | input | 1 | Frame length select: 0 = `FRAME_A_CYC`, 1 = `FRAME_B_CYC` |
| tx_we | input | 1 | Transmit register file write enable |
| tx_addr | input | $clog2(NBYTES) | Transmit entry to write |
| tx_wdata | input | DW | Transmit write data |
| rx_addr | input | $clog2(NBYTES) | Receive entry to read |
| rx_rdata | output | DW | Receive entry contents |
| busy | input | 1 | Peer not ready; sampled at slot boundaries |
| miso | input | 1 | Serial data from the peer |
| cs | output | 1 | Chip-select, high for the whole packet |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peer |
| done | output | 1 | One-cycle pulse when chip-select falls |
| overrun | output | 1 | Sticky flag: a frame tick hit an open packet |

## Verification
A byte index that slips or advances on a skipped slot appears at once as a wrong byte in the mosi scoreboard, within the same eight-clock byte. It appears again when the packet ends, as a rising-edge count other than 200 or as received data landing in the wrong entry. A slot counter or frame counter that is off shows up as byte-start spacing or chip-select intervals that differ from the parameter by the first packet. Busy-gating faults show as a first-edge delay that does not grow by exactly one slot per busy slot. A broken end-of-packet path shows as a done pulse that does not line up with the chip-select fall in the very cycle it should.

// File: rtl/sm_pkg.sv
package sm_pkg;

   typedef enum logic {
      LNK_IDLE = 1'b0,
      LNK_XFER = 1'b1
   } link_state_t;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sm_frame_timer.sv
module sm_frame_timer #(
   parameter int unsigned PER_A = 1_660_000,
   parameter int unsigned PER_B = 2_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   output logic tick
);
   localparam int unsigned PER_MAX = sm_pkg::max2(PER_A, PER_B);
   localparam int          CW      = $clog2(PER_MAX + 1);

   if (PER_A < 2 || PER_B < 2) begin : g_bad_per
      $error("sm_frame_timer: frame periods must be at least 2 cycles");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] per_q;
   logic          wrap;

   assign wrap = (cnt_q == per_q - CW'(1));
   assign tick = wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (wrap) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   if (PER_A == PER_B) begin : g_fixed
      assign per_q = CW'(PER_A);
   end else begin : g_select
      logic [CW-1:0] per_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            per_r <= CW'(PER_A);
         end else if (wrap) begin
            per_r <= sel ? CW'(PER_B) : CW'(PER_A);
         end
      end
      assign per_q = per_r;
   end

endmodule

// File: rtl/sm_shifter.sv
module sm_shifter #(
   parameter int unsigned DW       = 8,
   parameter int unsigned HALF_CYC = 30
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] tx_byte,
   input  logic          miso,
   output logic          sclk,
   output logic          mosi,
   output logic          run,
   output logic          done,
   output logic [DW-1:0] rx_byte
);
   localparam int BW = (DW > 1) ? $clog2(DW) : 1;

   if (DW < 2) begin : g_bad_dw
      $error("sm_shifter: DW must be at least 2");
   end
   if (HALF_CYC < 1) begin : g_bad_half
      $error("sm_shifter: HALF_CYC must be at least 1");
   end

   logic          run_q;
   logic          sclk_q;
   logic          done_q;
   logic [DW-1:0] txs_q;
   logic [DW-1:0] rxs_q;
   logic [BW-1:0] bits_q;
   logic          edge_due;

   if (HALF_CYC == 1) begin : g_div_none
      assign edge_due = run_q;
   end else begin : g_div_cnt
      localparam int DCW = $clog2(HALF_CYC);
      logic [DCW-1:0] div_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (start || !run_q) begin
            div_q <= '0;
         end else if (div_q == DCW'(HALF_CYC - 1)) begin
            div_q <= '0;
         end else begin
            div_q <= div_q + DCW'(1);
         end
      end
      assign edge_due = run_q && (div_q == DCW'(HALF_CYC - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
         txs_q  <= '0;
         rxs_q  <= '0;
         bits_q <= '0;
      end else if (start) begin
         run_q  <= 1'b1;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
         txs_q  <= tx_byte;
         bits_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (edge_due) begin
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rxs_q  <= {rxs_q[DW-2:0], miso};
            end else begin
               sclk_q <= 1'b0;
               txs_q  <= {txs_q[DW-2:0], 1'b0};
               if (bits_q == BW'(DW - 1)) begin
                  run_q  <= 1'b0;
                  done_q <= 1'b1;
               end else begin
                  bits_q <= bits_q + BW'(1);
               end
            end
         end
      end
   end

   assign sclk    = sclk_q;
   assign mosi    = run_q & txs_q[DW-1];
   assign run     = run_q;
   assign done    = done_q;
   assign rx_byte = rxs_q;

endmodule

// File: rtl/sm_regfile.sv
module sm_regfile #(
   parameter int unsigned DEPTH = 25,
   parameter int unsigned DW    = 8,
   localparam int         AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DEPTH*DW-1:0] flat;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [DW-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q <= '0;
         end else if (we && (waddr == AW'(e))) begin
            ent_q <= wdata;
         end
      end
      assign flat[e*DW +: DW] = ent_q;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (raddr == AW'(i)) begin
            rdata = flat[i*DW +: DW];
         end
      end
   end

endmodule

// File: rtl/busy_serial_master.sv
module busy_serial_master #(
   parameter int unsigned NBYTES      = 25,
   parameter int unsigned DW          = 8,
   parameter int unsigned HALF_CYC    = 30,
   parameter int unsigned SLOT_CYC    = 40_000,
   parameter int unsigned FRAME_A_CYC = 1_660_000,
   parameter int unsigned FRAME_B_CYC = 2_000_000
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      frame_sel,
   input  logic                      tx_we,
   input  logic [$clog2(NBYTES)-1:0] tx_addr,
   input  logic [DW-1:0]             tx_wdata,
   input  logic [$clog2(NBYTES)-1:0] rx_addr,
   output logic [DW-1:0]             rx_rdata,
   input  logic                      busy,
   input  logic                      miso,
   output logic                      cs,
   output logic                      sclk,
   output logic                      mosi,
   output logic                      done,
   output logic                      overrun
);
   import sm_pkg::*;

   localparam int          AW       = $clog2(NBYTES);
   localparam int          SCW      = $clog2(SLOT_CYC);
   localparam int unsigned BYTE_CYC = 2 * HALF_CYC * DW + 1;

   if (NBYTES < 2) begin : g_bad_n
      $error("busy_serial_master: NBYTES must be at least 2");
   end
   if (SLOT_CYC <= BYTE_CYC) begin : g_bad_slot
      $error("busy_serial_master: SLOT_CYC must exceed one byte time");
   end

   link_state_t   st_q;
   logic [AW-1:0] idx_q;
   logic [SCW-1:0] slot_q;
   logic          done_q;
   logic          ovr_q;

   logic          tick;
   logic          slot_edge;
   logic          eng_start;
   logic          eng_run;
   logic          eng_done;
   logic          last_byte;
   logic [DW-1:0] eng_tx;
   logic [DW-1:0] eng_rx;

   sm_frame_timer #(
      .PER_A (FRAME_A_CYC),
      .PER_B (FRAME_B_CYC)
   ) u_frame (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (frame_sel),
      .tick  (tick)
   );

   sm_regfile #(
      .DEPTH (NBYTES),
      .DW    (DW)
   ) u_txf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tx_we),
      .waddr (tx_addr),
      .wdata (tx_wdata),
      .raddr (idx_q),
      .rdata (eng_tx)
   );

   sm_regfile #(
      .DEPTH (NBYTES),
      .DW    (DW)
   ) u_rxf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (eng_done),
      .waddr (idx_q),
      .wdata (eng_rx),
      .raddr (rx_addr),
      .rdata (rx_rdata)
   );

   sm_shifter #(
      .DW       (DW),
      .HALF_CYC (HALF_CYC)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (eng_start),
      .tx_byte (eng_tx),
      .miso    (miso),
      .sclk    (sclk),
      .mosi    (mosi),
      .run     (eng_run),
      .done    (eng_done),
      .rx_byte (eng_rx)
   );

   assign slot_edge = (st_q == LNK_XFER) && (slot_q == '0);
   assign eng_start = slot_edge && !eng_run && !busy;
   assign last_byte = (idx_q == AW'(NBYTES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= LNK_IDLE;
         idx_q  <= '0;
         slot_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (st_q == LNK_IDLE) begin
            if (tick) begin
               st_q   <= LNK_XFER;
               idx_q  <= '0;
               slot_q <= '0;
            end
         end else begin
            if (slot_q == SCW'(SLOT_CYC - 1)) begin
               slot_q <= '0;
            end else begin
               slot_q <= slot_q + SCW'(1);
            end
            if (eng_done) begin
               if (last_byte) begin
                  st_q   <= LNK_IDLE;
                  done_q <= 1'b1;
               end else begin
                  idx_q <= idx_q + AW'(1);
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
      end else if (tick && (st_q == LNK_XFER)) begin
         ovr_q <= 1'b1;
      end
   end

   assign cs      = (st_q == LNK_XFER);
   assign done    = done_q;
   assign overrun = ovr_q;

endmodule

// File: rtl/sm_link_checker.sv
module sm_link_checker (
   input logic clk,
   input logic rst_n,
   input logic cs,
   input logic sclk,
   input logic mosi,
   input logic done,
   input logic overrun
);

   // R4
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> !sclk);

   // R5
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   // R9
   done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs) |-> done);

   // R9
   done_only_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!cs && $past(cs)));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);

endmodule

bind busy_serial_master sm_link_checker u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cs      (cs),
   .sclk    (sclk),
   .mosi    (mosi),
   .done    (done),
   .overrun (overrun)
);

// File: tb/sim_busy_serial_master.sv
module sim_busy_serial_master;
   localparam int HALF = 2;
   localparam int SLOT = 40;
   localparam int FA   = 1200;
   localparam int FB   = 1500;
   localparam int NB   = 25;
   localparam int DW   = 8;
   localparam int AW   = $clog2(NB);
   localparam int NP   = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_sel = 1'b0;
   logic          tx_we = 1'b0;
   logic [AW-1:0] tx_addr = '0;
   logic [DW-1:0] tx_wdata = '0;
   logic [AW-1:0] rx_addr = '0;
   logic [DW-1:0] rx_rdata;
   logic          busy = 1'b0;
   logic          miso = 1'b0;
   logic          cs, sclk, mosi, done, overrun;

   busy_serial_master #(
      .NBYTES (NB), .DW (DW), .HALF_CYC (HALF), .SLOT_CYC (SLOT),
      .FRAME_A_CYC (FA), .FRAME_B_CYC (FB)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .frame_sel (frame_sel),
      .tx_we (tx_we), .tx_addr (tx_addr), .tx_wdata (tx_wdata),
      .rx_addr (rx_addr), .rx_rdata (rx_rdata),
      .busy (busy), .miso (miso),
      .cs (cs), .sclk (sclk), .mosi (mosi), .done (done), .overrun (overrun)
   );

   always #5 clk = ~clk;

   int errs = 0;
   int checks = 0;
   bit finished = 0;

   logic [DW-1:0] tx_model [NB];
   logic [DW-1:0] peer_tx  [NB];
   logic [DW-1:0] exp_q [$];

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: loads the transmit file through the port and keeps the model
   task automatic load_tx(input int seed);
      for (int i = 0; i < NB; i++) begin
         @(negedge clk);
         tx_we    = 1'b1;
         tx_addr  = AW'(i);
         tx_wdata = DW'(i * 37 + seed * 91 + 5);
         tx_model[i] = DW'(i * 37 + seed * 91 + 5);
      end
      @(negedge clk);
      tx_we = 1'b0;
   endtask

   task automatic set_peer(input int seed);
      for (int i = 0; i < NB; i++) peer_tx[i] = DW'((i * 11 + seed * 53) ^ 8'hA5);
   endtask

   // driver side of the scoreboard: expected bytes of one packet
   task automatic push_packet();
      for (int i = 0; i < NB; i++) exp_q.push_back(tx_model[i]);
   endtask

   task automatic check_rx(input string req);
      int bad = 0;
      int first_a = 0, first_e = 0;
      for (int i = 0; i < NB; i++) begin
         rx_addr = AW'(i);
         #1;
         if (rx_rdata !== peer_tx[i]) begin
            if (bad == 0) begin first_a = int'(rx_rdata); first_e = int'(peer_tx[i]); end
            bad++;
         end
      end
      chk(bad == 0, req, first_a, first_e);
   endtask

   // monitor state
   int  cyc = 0;
   bit  p_cs = 0, p_sclk = 0;
   int  n_start = 0, n_end = 0, cur = 0;
   int  cs_rise [NP];
   int  rises   [NP];
   int  bstart  [NP][NB];
   int  rbit = 0, pbit = 0, pidx = 0, bcount = 0;
   logic [DW-1:0] cap = '0;

   always @(negedge clk) begin
      cyc++;
      if (!rst_n) begin
         p_cs = 0;
         p_sclk = 0;
      end else begin
         if (cs && !p_cs) begin
            cur = (n_start < NP) ? n_start : NP - 1;
            cs_rise[cur] = cyc;
            rises[cur] = 0;
            rbit = 0; pbit = 0; pidx = 0; bcount = 0;
            push_packet();
            n_start++;
         end
         if (sclk && !p_sclk && cs) begin
            if (rbit == 0) begin
               if (bcount < NB) bstart[cur][bcount] = cyc;
               bcount++;
            end
            rises[cur]++;
            cap = {cap[DW-2:0], mosi};
            rbit++;
            if (rbit == DW) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R5 unexpected byte on mosi", int'(cap), -1);
               end else begin
                  logic [DW-1:0] e;
                  e = exp_q.pop_front();
                  chk(cap == e, "R5 mosi byte", int'(cap), int'(e));
               end
            end
         end
         if (!sclk && p_sclk) begin
            if (rbit == DW) begin
               rbit = 0;
               pidx++;
            end
            pbit = rbit;
         end
         if (!cs && p_cs) begin
            chk(done == 1'b1, "R9 done at cs fall", int'(done), 1);
            n_end++;
         end else if (done) begin
            chk(1'b0, "R9 done away from cs fall", int'(done), 0);
         end
         miso = (pidx < NB) ? peer_tx[pidx][DW-1-pbit] : 1'b0;
         p_cs = cs;
         p_sclk = sclk;
      end
   end

   function automatic int spacing_bad(input int p, input int skip_at);
      int bad = 0;
      for (int k = 1; k < NB; k++) begin
         int want = (k == skip_at) ? 2 * SLOT : SLOT;
         if (bstart[p][k] - bstart[p][k-1] != want) bad++;
      end
      return bad;
   endfunction

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_end, 6);
      finish_run();
   end

   initial begin
      set_peer(0);
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cs == 0 && sclk == 0 && mosi == 0, "R1 link idle in reset", int'({cs, sclk, mosi}), 0);
      chk(done == 0 && overrun == 0, "R1 flags low in reset", int'({done, overrun}), 0);
      rst_n = 1'b1;
      load_tx(0);
      chk(cs == 0 && sclk == 0, "R1 idle before first tick", int'({cs, sclk}), 0);

      // packet 0: plain transfer
      wait (n_end == 1);
      @(negedge clk);
      chk(bstart[0][0] - cs_rise[0] == HALF + 1, "R4 first edge delay", bstart[0][0] - cs_rise[0], HALF + 1);
      chk(rises[0] == NB * DW, "R3 edges per packet", rises[0], NB * DW);
      chk(spacing_bad(0, -1) == 0, "R7 byte spacing", spacing_bad(0, -1), 0);
      chk(exp_q.size() == 0, "R3 all bytes delivered", exp_q.size(), 0);
      check_rx("R6 rx file contents pkt0");
      frame_sel = 1'b1;

      // packet 1: frame A length seen
      wait (n_end == 2);
      @(negedge clk);
      chk(cs_rise[1] - cs_rise[0] == FA, "R2 frame length A", cs_rise[1] - cs_rise[0], FA);
      load_tx(1);
      set_peer(1);
      busy = 1'b1;

      // packet 2: three busy slots at the start
      wait (n_start == 3);
      repeat (3 * SLOT - 10) @(negedge clk);
      busy = 1'b0;
      wait (n_end == 3);
      @(negedge clk);
      chk(cs_rise[2] - cs_rise[1] == FB, "R2 frame length B", cs_rise[2] - cs_rise[1], FB);
      chk(bstart[2][0] - cs_rise[2] == 3 * SLOT + HALF + 1, "R8 skipped slots delay",
          bstart[2][0] - cs_rise[2], 3 * SLOT + HALF + 1);
      chk(rises[2] == NB * DW, "R8 no byte lost to skips", rises[2], NB * DW);
      check_rx("R6 rx file contents pkt2");
      chk(overrun == 0, "R10 no overrun yet", int'(overrun), 0);

      // packet 3: one busy slot in the middle
      wait (n_start == 4);
      wait (bcount == 11);
      repeat (5) @(negedge clk);
      busy = 1'b1;
      repeat (SLOT) @(negedge clk);
      busy = 1'b0;
      wait (n_end == 4);
      @(negedge clk);
      chk(bstart[3][11] - bstart[3][10] == 2 * SLOT, "R8 mid-packet skip",
          bstart[3][11] - bstart[3][10], 2 * SLOT);
      chk(spacing_bad(3, 11) == 0, "R7 spacing around skip", spacing_bad(3, 11), 0);
      chk(rises[3] == NB * DW && exp_q.size() == 0, "R3 full packet after skip", rises[3], NB * DW);
      busy = 1'b1;

      // packet 4: long enough to swallow a frame tick
      wait (n_start == 5);
      repeat (14 * SLOT - 10) @(negedge clk);
      busy = 1'b0;
      wait (n_end == 5);
      @(negedge clk);
      chk(overrun == 1, "R10 overrun set", int'(overrun), 1);
      chk(n_start == 5, "R10 tick did not restart", n_start, 5);
      chk(rises[4] == NB * DW, "R10 packet completed", rises[4], NB * DW);

      wait (n_end == 6);
      @(negedge clk);
      chk(cs_rise[5] - cs_rise[4] == 2 * FB, "R10 dropped tick", cs_rise[5] - cs_rise[4], 2 * FB);
      chk(overrun == 1, "R10 overrun sticky", int'(overrun), 1);
      check_rx("R6 rx file contents pkt5");
      finish_run();
   end

endmodule